// File: doc/BRIEF.md
# Single-Wire Unary Count Transmitter

This block sends a decimal value from 0 to 9999 over one output wire. The wire idles low. A start strobe begins a frame. The frame opens with one long high pulse, which tells the receiver to clear its count. A number of short high pulses follows, one for each unit of the value, and the receiver counts them. The receiver keeps the last value it counted without any refresh, so a frame is needed only when the value changes. The caller decides how often to start a frame.

Every width is a parameter counted in system clock cycles: the long pulse, the high time of a short pulse, and the low time of a short pulse. With a 1 MHz clock the defaults give a 5 ms clearing pulse, which is well above a 1 ms receiver discrimination threshold, and short pulses that are 2 µs high and 2 µs low. A frame at the largest value then takes 5000 + 9999·4 = 44 996 cycles, which is within 45 ms. The block raises a busy flag while it sends and gives a one-cycle done pulse at the end of the frame.

Top module: `pulse_count_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `line_o`, `busy_o` and `done_o` are all low.
- R2: A strobe on `start_i` that is sampled while the block is idle raises `busy_o` and `line_o` at the next clock edge. `line_o` then stays high for exactly LONG_CYC cycles, which is the clearing pulse.
- R3: When the value is not zero, `line_o` stays low for exactly LOW_CYC cycles between the end of the clearing pulse and the first short pulse.
- R4: After the clearing pulse the block emits exactly N short pulses, where N is the captured value. Each short pulse is high for HIGH_CYC cycles, and consecutive short pulses are separated by LOW_CYC low cycles.
- R5: A value of zero sends only the clearing pulse. In that case `busy_o` is high for exactly LONG_CYC cycles.
- R6: A value above MAX_VAL (default 9999) is sent as MAX_VAL short pulses.
- R7: A strobe that arrives while `busy_o` is high is ignored. `value_i` is captured only in the cycle the strobe is accepted, and later changes to it do not alter the frame.
- R8: `busy_o` stays high for exactly LONG_CYC + N·(HIGH_CYC + LOW_CYC) cycles. `done_o` is high for one cycle, in the same cycle that `busy_o` first reads low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to send `value_i` |
| value_i | input | VAL_W | Value to send, binary |
| line_o | output | 1 | Single-wire pulse output, idles low |
| busy_o | output | 1 | High while a frame is being sent |
| done_o | output | 1 | One-cycle pulse at the end of a frame |

## Verification
The assertions assume three things:
- Every width parameter is at least one cycle.
- LONG_CYC is larger than HIGH_CYC, so that the two pulse kinds have distinct widths.
- `start_i` is a synchronous level sampled on the clock.

The width checks compare the length of every high run with one of the two legal widths. They would therefore not tell the pulse kinds apart if the two parameters were equal. For this reason the bench overrides the widths with short, distinct values (20, 2 and 3 cycles). It drives `start_i` and `value_i` only at falling edges, and it sends strobes during a frame only to test that they are ignored.

// File: rtl/pct_pkg.sv
package pct_pkg;

    typedef enum logic [1:0] {
        PCT_IDLE  = 2'd0,
        PCT_CLEAR = 2'd1,
        PCT_LOW   = 2'd2,
        PCT_HIGH  = 2'd3
    } pct_state_e;

endpackage

// File: rtl/pct_clamp.sv
module pct_clamp #(
    parameter int unsigned VAL_W   = 14,
    parameter int unsigned MAX_VAL = 9999
) (
    input  logic [VAL_W-1:0] raw_i,
    output logic [VAL_W-1:0] lim_o
);
    localparam logic [VAL_W-1:0] LIMIT = VAL_W'(MAX_VAL);

    always_comb begin
        lim_o = (raw_i > LIMIT) ? LIMIT : raw_i;
    end
endmodule

// File: rtl/pct_timer.sv
module pct_timer #(
    parameter int unsigned TW = 13
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          load_i,
    input  logic [TW-1:0] load_val_i,
    output logic          expired_o
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired_o = (cnt_q == '0);

    // R8: once loaded, the countdown never wraps past zero
    no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/pulse_count_tx.sv
module pulse_count_tx #(
    parameter int unsigned VAL_W    = 14,
    parameter int unsigned MAX_VAL  = 9999,
    parameter int unsigned LONG_CYC = 5000,
    parameter int unsigned HIGH_CYC = 2,
    parameter int unsigned LOW_CYC  = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [VAL_W-1:0] value_i,
    output logic             line_o,
    output logic             busy_o,
    output logic             done_o
);
    import pct_pkg::*;

    localparam int unsigned MAX_W   = (LONG_CYC > HIGH_CYC) ?
                                      ((LONG_CYC > LOW_CYC) ? LONG_CYC : LOW_CYC) :
                                      ((HIGH_CYC > LOW_CYC) ? HIGH_CYC : LOW_CYC);
    localparam int unsigned TW      = $clog2(MAX_W + 1);
    localparam logic [TW-1:0] LONG_LD = TW'(LONG_CYC - 1);
    localparam logic [TW-1:0] HIGH_LD = TW'(HIGH_CYC - 1);
    localparam logic [TW-1:0] LOW_LD  = TW'(LOW_CYC - 1);
    localparam logic [VAL_W-1:0] LIMIT = VAL_W'(MAX_VAL);

    typedef struct packed {
        pct_state_e       st;
        logic [VAL_W-1:0] left;
        logic             line;
        logic             busy;
        logic             done;
    } tx_regs_t;

    tx_regs_t          r_d, r_q;
    logic [VAL_W-1:0]  val_lim;
    logic              tmr_load;
    logic [TW-1:0]     tmr_val;
    logic              tmr_exp;

    pct_clamp #(.VAL_W(VAL_W), .MAX_VAL(MAX_VAL)) i_clamp (
        .raw_i (value_i),
        .lim_o (val_lim)
    );

    pct_timer #(.TW(TW)) i_timer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_exp)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (r_q.st)
            PCT_IDLE: begin
                if (start_i) begin
                    r_d.st   = PCT_CLEAR;
                    r_d.left = val_lim;
                    tmr_load = 1'b1;
                    tmr_val  = LONG_LD;
                end
            end
            PCT_CLEAR: begin
                if (tmr_exp) begin
                    if (r_q.left == '0) begin
                        r_d.st   = PCT_IDLE;
                        r_d.done = 1'b1;
                    end else begin
                        r_d.st   = PCT_LOW;
                        tmr_load = 1'b1;
                        tmr_val  = LOW_LD;
                    end
                end
            end
            PCT_LOW: begin
                if (tmr_exp) begin
                    r_d.st   = PCT_HIGH;
                    tmr_load = 1'b1;
                    tmr_val  = HIGH_LD;
                end
            end
            PCT_HIGH: begin
                if (tmr_exp) begin
                    r_d.left = r_q.left - 1'b1;
                    if (r_q.left == VAL_W'(1)) begin
                        r_d.st   = PCT_IDLE;
                        r_d.done = 1'b1;
                    end else begin
                        r_d.st   = PCT_LOW;
                        tmr_load = 1'b1;
                        tmr_val  = LOW_LD;
                    end
                end
            end
            default: r_d.st = PCT_IDLE;
        endcase
        r_d.line = (r_d.st == PCT_CLEAR) || (r_d.st == PCT_HIGH);
        r_d.busy = (r_d.st != PCT_IDLE);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            r_q <= '{st: PCT_IDLE, left: '0, line: 1'b0, busy: 1'b0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign line_o = r_q.line;
    assign busy_o = r_q.busy;
    assign done_o = r_q.done;

    // length of the current high run on the wire, used by the width check
    logic [TW-1:0] hrun_q;
    always_ff @(posedge clk_i) begin
        if (!rst_ni) hrun_q <= '0;
        else         hrun_q <= line_o ? hrun_q + 1'b1 : '0;
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> !line_o);

    // R2
    pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(line_o) |-> (hrun_q == TW'(LONG_CYC) || hrun_q == TW'(HIGH_CYC)));

    // R6
    count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        r_q.left <= LIMIT);

    // R7
    busy_start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && start_i) |=> (r_q.left <= $past(r_q.left)));

    // R8
    done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R8
    done_ends_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (!busy_o && $past(busy_o)));
endmodule

// File: tb/test_pulse_count_tx.sv
module test_pulse_count_tx;
    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned VAL_W = 14;
    localparam int unsigned LONG  = 20;
    localparam int unsigned HI    = 2;
    localparam int unsigned LO    = 3;
    localparam int unsigned NVEC  = 6;
    // {input value, expected pulse count}
    localparam int unsigned VEC [NVEC][2] = '{
        '{0, 0}, '{1, 1}, '{3, 3}, '{17, 17}, '{9999, 9999}, '{12000, 9999}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [VAL_W-1:0] value = '0;
    logic line, busy, done;
    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pulse_count_tx #(.VAL_W(VAL_W), .MAX_VAL(9999), .LONG_CYC(LONG),
                     .HIGH_CYC(HI), .LOW_CYC(LO)) i_pulse_count_tx (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .value_i(value),
        .line_o(line), .busy_o(busy), .done_o(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // send one frame, optionally disturbing the inputs at busy cycle inj
    task automatic send(input int unsigned v, input int unsigned n, input int inj);
        int cyc = 0, run = 0, nhi = 0, lw = 0, gap = -1, bad = 0, ndone = 0;
        logic prev = 1'b0;
        @(negedge clk);
        value = VAL_W'(v);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        forever begin
            if (busy) cyc++;
            if (done) ndone++;
            if (line == prev) begin
                run++;
            end else begin
                if (prev) begin
                    nhi++;
                    if (nhi == 1) lw = run;
                    else if (run != int'(HI)) bad++;
                end else if (nhi >= 1) begin
                    if (nhi == 1) gap = run;
                    else if (run != int'(LO)) bad++;
                end
                run = 1;
            end
            prev = line;
            if (!busy) break;
            if (inj > 0 && cyc == inj) begin
                start = 1'b1;
                value = VAL_W'(40);
            end else if (inj > 0 && cyc == inj + 1) begin
                start = 1'b0;
                value = VAL_W'(77);
            end
            @(negedge clk);
        end
        check(lw == int'(LONG), "R2 clear pulse width", lw, LONG);
        check(nhi - 1 == int'(n), "R4 short pulse count", nhi - 1, n);
        check(bad == 0, "R4 short pulse/gap widths", bad, 0);
        if (n > 0) check(gap == int'(LO), "R3 gap after clear", gap, LO);
        check(cyc == int'(LONG + n * (HI + LO)), "R8 busy length", cyc, LONG + n * (HI + LO));
        check(done == 1'b1 && ndone == 1, "R8 done with busy low", ndone, 1);
        @(negedge clk);
        check(done == 1'b0 && line == 1'b0, "R1 quiet after frame", {done, line}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(line == 1'b0 && busy == 1'b0 && done == 1'b0, "R1 reset state",
              {line, busy, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // table walk: R4 main, R5 zero, R6 clamp
        for (int i = 0; i < int'(NVEC); i++) begin
            send(VEC[i][0], VEC[i][1], 0);
        end
        // R7: strobe with new value mid-frame, then value change, ignored
        send(5, 5, 10);
        // R7: strobe during the clear pulse of a zero frame
        send(0, 0, 4);
        // R5: zero frame busy exactly LONG cycles checked in send; idle check
        repeat (4) @(negedge clk);
        check(busy == 1'b0 && line == 1'b0, "R1 idle without strobe", {busy, line}, 0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule